// File: doc/BRIEF.md
# SDRAM command decoder with bank tracking

This block is the command front end of a four-bank synchronous DRAM, seen from the device side. On each rising clock edge it samples the chip select, the three command strobes, the bank select and the address pins. It turns them into a command, checks that command against the open or idle state of the addressed bank, and keeps that state and the open row of every bank up to date. The result is a registered report for the rest of the device: the command taken, whether it was accepted or refused as illegal, the column and bank of a read or write, and the auto-precharge request.

Address bit 10 does two jobs. On a read or write it asks for the bank to close once the access completes. On a precharge it widens the precharge to all four banks. Clock enable low moves the block into a sleep mode. A refresh command with all banks idle enters self-refresh, and anything else enters power-down. While the block sleeps, commands are ignored and bank state is kept.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: After reset all four banks are idle, every stored row, the column and column bank are zero, cmd_o is 3'b111, every flag is low and the block is awake.
- R2: The command code is {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 000 mode register set, 111 no-operation. With cs_n high, nothing is executed: cmd_o reads 111, cmd_valid_o is low and bank state is unchanged. A no-operation gives cmd_valid_o high.
- R3: An activate to an idle bank (selected by ba) opens it and stores addr[12:0] as its open row on open_row_o[ba*13 +: 13].
- R4: A read or write to an open bank sets cmd_valid_o and loads col_o with addr[8:0] and col_bank_o with ba. The other address bits have no effect on the column. col_o and col_bank_o hold their value until the next accepted read or write.
- R5: On an accepted read or write, addr[10] high raises auto_pre_o for that cycle and returns the bank to idle. With addr[10] low, auto_pre_o stays low and the bank stays open.
- R6: A precharge is always accepted. With addr[10] high it idles all four banks whatever ba says. With addr[10] low it idles only bank ba.
- R7: A read or write to an idle bank, an activate to an open bank, or the unsupported code 110 raises illegal_o with cmd_valid_o low and changes no bank state.
- R8: An auto refresh is accepted only when all four banks are idle. Otherwise it is illegal.
- R9: A mode register set is accepted in any bank state and changes no bank state.
- R10: When cke is sampled low while awake, the block enters self-refresh (sr_o) if the sampled command is an auto refresh with all banks idle, and power-down (pd_o) otherwise. No command executes on the entry edge or while asleep. The edge that samples cke high again wakes the block, and its command is ignored.
- R11: All outputs are registered. They show the result of the command sampled at the latest rising edge, so illegal_o and auto_pre_o last exactly one cycle per offending or requesting command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all pins sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cke | input | 1 | Clock enable, low requests sleep |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, command bit 2 |
| cas_n | input | 1 | Column strobe, command bit 1 |
| we_n | input | 1 | Write enable, command bit 0 |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, column and bit-10 control address |
| cmd_o | output | 3 | Code of the sampled selected command, 111 otherwise |
| cmd_valid_o | output | 1 | The sampled command was accepted |
| illegal_o | output | 1 | The sampled command was refused |
| col_o | output | 9 | Column of the last accepted read or write |
| col_bank_o | output | 2 | Bank of the last accepted read or write |
| auto_pre_o | output | 1 | Auto-precharge requested by the accepted read or write |
| bank_open_o | output | 4 | One bit per bank, high when open |
| open_row_o | output | 52 | Stored row per bank, 13 bits each, bank 0 lowest |
| pd_o | output | 1 | Power-down mode |
| sr_o | output | 1 | Self-refresh mode |

## Verification
The assertions check on every cycle that a refusal leaves the bank bits unchanged, that accepted and illegal never coincide, that an accepted activate opens exactly one more bank, that self-refresh and accepted refreshes only occur with every bank idle, and that no command is accepted on the edge after a sleep cycle. The bench compares all outputs against a behavioural model on every clock. Only its scenarios can show which bank and row an activate touched, the column picked out of a wide address, the single-bank versus all-bank precharge split, and the choice between power-down and self-refresh.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    PM_AWAKE = 2'd0,
    PM_PDOWN = 2'd1,
    PM_SREF  = 2'd2
  } pmode_e;

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 run,
  input  logic                 cs_n,
  input  cmd_e                 code,
  input  logic [BANK_W-1:0]    ba,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bank_open,
  output logic                 sel,
  output logic                 accept,
  output logic                 illegal,
  output logic                 rw_acc,
  output logic                 ap_req,
  output logic [NUM_BANKS-1:0] open_mask,
  output logic [NUM_BANKS-1:0] close_mask
);

  logic                 tgt_open;
  logic                 all_idle;
  logic [NUM_BANKS-1:0] bank_dec;

  always_comb begin
    bank_dec     = '0;
    bank_dec[ba] = 1'b1;
  end

  assign tgt_open = bank_open[ba];
  assign all_idle = ~|bank_open;
  assign sel      = run & ~cs_n;

  always_comb begin
    accept     = 1'b0;
    illegal    = 1'b0;
    rw_acc     = 1'b0;
    ap_req     = 1'b0;
    open_mask  = '0;
    close_mask = '0;
    if (sel) begin
      unique case (code)
        CMD_ACT: begin
          if (tgt_open) begin
            illegal = 1'b1;
          end else begin
            accept    = 1'b1;
            open_mask = bank_dec;
          end
        end
        CMD_RD, CMD_WR: begin
          if (!tgt_open) begin
            illegal = 1'b1;
          end else begin
            accept = 1'b1;
            rw_acc = 1'b1;
            ap_req = addr[AP_BIT];
            if (addr[AP_BIT]) begin
              close_mask = bank_dec;
            end
          end
        end
        CMD_PRE: begin
          accept     = 1'b1;
          close_mask = addr[AP_BIT] ? {NUM_BANKS{1'b1}} : bank_dec;
        end
        CMD_REF: begin
          if (all_idle) begin
            accept = 1'b1;
          end else begin
            illegal = 1'b1;
          end
        end
        CMD_MRS, CMD_NOP: begin
          accept = 1'b1;
        end
        default: begin
          illegal = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS-1:0]       open_mask,
  input  logic [NUM_BANKS-1:0]       close_mask,
  input  logic [ROW_W-1:0]           row_in,
  output logic [NUM_BANKS-1:0]       bank_open,
  output logic [NUM_BANKS*ROW_W-1:0] open_row
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             open_q, open_d, open_en;
    logic [ROW_W-1:0] row_q;

    assign open_en = open_mask[b] | close_mask[b];
    assign open_d  = open_mask[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
      end else if (open_en) begin
        open_q <= open_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (open_mask[b]) begin
        row_q <= row_in;
      end
    end

    assign bank_open[b]                 = open_q;
    assign open_row[b*ROW_W +: ROW_W]   = row_q;
  end

endmodule

// File: rtl/sdram_power_ctl.sv
module sdram_power_ctl
  import sdram_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic ref_sel,
  input  logic all_idle,
  output logic run,
  output logic pd,
  output logic sr
);

  pmode_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_AWAKE: begin
        if (!cke) begin
          state_d = (ref_sel && all_idle) ? PM_SREF : PM_PDOWN;
        end
      end
      PM_PDOWN, PM_SREF: begin
        if (cke) begin
          state_d = PM_AWAKE;
        end
      end
      default: state_d = PM_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_AWAKE;
    end else begin
      state_q <= state_d;
    end
  end

  assign run = (state_q == PM_AWAKE) && cke;
  assign pd  = (state_q == PM_PDOWN);
  assign sr  = (state_q == PM_SREF);

endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = ROW_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [BANK_W-1:0]          ba,
  input  logic [ADDR_W-1:0]          addr,
  output logic [2:0]                 cmd_o,
  output logic                       cmd_valid_o,
  output logic                       illegal_o,
  output logic [COL_W-1:0]           col_o,
  output logic [BANK_W-1:0]          col_bank_o,
  output logic                       auto_pre_o,
  output logic [NUM_BANKS-1:0]       bank_open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  output logic                       pd_o,
  output logic                       sr_o
);

  logic                 rst_int_n;
  cmd_e                 code;
  logic                 run, sel, accept, illegal, rw_acc, ap_req;
  logic                 ref_sel, all_idle;
  logic [NUM_BANKS-1:0] open_mask, close_mask;

  cmd_e                 cmd_q, cmd_d;
  logic                 valid_q, ill_q, ap_q;
  logic [COL_W-1:0]     col_q;
  logic [BANK_W-1:0]    cb_q;

  assign code     = cmd_e'({ras_n, cas_n, we_n});
  assign ref_sel  = ~cs_n && (code == CMD_REF);
  assign all_idle = ~|bank_open_o;

  sdram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sdram_power_ctl u_pwr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cke      (cke),
    .ref_sel  (ref_sel),
    .all_idle (all_idle),
    .run      (run),
    .pd       (pd_o),
    .sr       (sr_o)
  );

  sdram_cmd_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .AP_BIT    (AP_BIT)
  ) u_dec (
    .run        (run),
    .cs_n       (cs_n),
    .code       (code),
    .ba         (ba),
    .addr       (addr),
    .bank_open  (bank_open_o),
    .sel        (sel),
    .accept     (accept),
    .illegal    (illegal),
    .rw_acc     (rw_acc),
    .ap_req     (ap_req),
    .open_mask  (open_mask),
    .close_mask (close_mask)
  );

  sdram_bank_tracker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W)
  ) u_banks (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .open_mask  (open_mask),
    .close_mask (close_mask),
    .row_in     (addr),
    .bank_open  (bank_open_o),
    .open_row   (open_row_o)
  );

  assign cmd_d = sel ? code : CMD_NOP;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q   <= CMD_NOP;
      valid_q <= 1'b0;
      ill_q   <= 1'b0;
      ap_q    <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      valid_q <= accept;
      ill_q   <= illegal;
      ap_q    <= rw_acc & ap_req;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      col_q <= '0;
      cb_q  <= '0;
    end else if (rw_acc) begin
      col_q <= addr[COL_W-1:0];
      cb_q  <= ba;
    end
  end

  assign cmd_o       = cmd_q;
  assign cmd_valid_o = valid_q;
  assign illegal_o   = ill_q;
  assign auto_pre_o  = ap_q;
  assign col_o       = col_q;
  assign col_bank_o  = cb_q;

endmodule

// File: rtl/sdram_cmd_decoder_checker.sv
module sdram_cmd_decoder_checker #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cmd_o,
  input logic                 cmd_valid_o,
  input logic                 illegal_o,
  input logic                 auto_pre_o,
  input logic [NUM_BANKS-1:0] bank_open_o,
  input logic                 pd_o,
  input logic                 sr_o
);

  assert_illegal_keeps_banks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (bank_open_o == $past(bank_open_o)));

  assert_accept_excludes_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_o && cmd_valid_o));

  assert_activate_opens_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_o == 3'b011) |->
      ($countones(bank_open_o) == $countones($past(bank_open_o)) + 1));

  assert_autopre_only_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre_o |-> (cmd_valid_o && (cmd_o == 3'b101 || cmd_o == 3'b100)));

  assert_refresh_all_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_o == 3'b001) |-> (bank_open_o == '0));

  assert_sleep_modes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pd_o && sr_o));

  assert_selfref_banks_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sr_o |-> (bank_open_o == '0));

  assert_sleep_blocks_cmds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pd_o || sr_o) |-> (!cmd_valid_o && !illegal_o));

endmodule

bind sdram_cmd_decoder sdram_cmd_decoder_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/sdram_cmd_decoder_test.sv
module sdram_cmd_decoder_test;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;

  logic [2:0]  cmd_o;
  logic        cmd_valid_o, illegal_o, auto_pre_o, pd_o, sr_o;
  logic [8:0]  col_o;
  logic [1:0]  col_bank_o;
  logic [3:0]  bank_open_o;
  logic [51:0] open_row_o;

  int tests_run;
  int tests_failed;

  // reference model state
  bit          m_open [4];
  logic [12:0] m_row  [4];
  int          m_mode;
  logic [2:0]  e_cmd;
  bit          e_valid, e_ill, e_ap;
  logic [8:0]  e_col;
  logic [1:0]  e_cb;

  sdram_cmd_decoder uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke         (cke),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ba          (ba),
    .addr        (addr),
    .cmd_o       (cmd_o),
    .cmd_valid_o (cmd_valid_o),
    .illegal_o   (illegal_o),
    .col_o       (col_o),
    .col_bank_o  (col_bank_o),
    .auto_pre_o  (auto_pre_o),
    .bank_open_o (bank_open_o),
    .open_row_o  (open_row_o),
    .pd_o        (pd_o),
    .sr_o        (sr_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 1'b0;
      m_row[b]  = '0;
    end
    m_mode  = 0;
    e_cmd   = 3'b111;
    e_valid = 1'b0;
    e_ill   = 1'b0;
    e_ap    = 1'b0;
    e_col   = '0;
    e_cb    = '0;
  endtask

  task automatic model_edge(input bit ck, input bit cs, input logic [2:0] c,
                            input logic [1:0] b, input logic [12:0] a);
    bit run, sel, idle;
    idle = !(m_open[0] || m_open[1] || m_open[2] || m_open[3]);
    run  = (m_mode == 0) && ck;
    sel  = run && !cs;
    e_valid = 1'b0;
    e_ill   = 1'b0;
    e_ap    = 1'b0;
    e_cmd   = sel ? c : 3'b111;
    if (sel) begin
      case (c)
        3'b011: if (m_open[b]) e_ill = 1'b1;
                else begin m_open[b] = 1'b1; m_row[b] = a; e_valid = 1'b1; end
        3'b101, 3'b100:
                if (!m_open[b]) e_ill = 1'b1;
                else begin
                  e_valid = 1'b1; e_col = a[8:0]; e_cb = b; e_ap = a[10];
                  if (a[10]) m_open[b] = 1'b0;
                end
        3'b010: begin
                  e_valid = 1'b1;
                  if (a[10]) for (int k = 0; k < 4; k++) m_open[k] = 1'b0;
                  else m_open[b] = 1'b0;
                end
        3'b001: if (idle) e_valid = 1'b1; else e_ill = 1'b1;
        3'b000, 3'b111: e_valid = 1'b1;
        default: e_ill = 1'b1;
      endcase
    end
    if (m_mode == 0 && !ck) m_mode = (!cs && c == 3'b001 && idle) ? 2 : 1;
    else if (m_mode != 0 && ck) m_mode = 0;
  endtask

  task automatic compare(input string tag);
    logic [74:0] got, exp;
    logic [3:0]  eo;
    logic [51:0] er;
    for (int b = 0; b < 4; b++) begin
      eo[b] = m_open[b];
      er[b*13 +: 13] = m_row[b];
    end
    exp = {e_cmd, e_valid, e_ill, e_col, e_cb, e_ap, eo, er, (m_mode == 1), (m_mode == 2)};
    got = {cmd_o, cmd_valid_o, illegal_o, col_o, col_bank_o, auto_pre_o,
           bank_open_o, open_row_o, pd_o, sr_o};
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input bit ck, input bit cs, input logic [2:0] c,
                      input logic [1:0] b, input logic [12:0] a, input string tag);
    cke = ck; cs_n = cs; {ras_n, cas_n, we_n} = c; ba = b; addr = a;
    @(posedge clk);
    model_edge(ck, cs, c, b, a);
    #(CLK_P/4);
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    tests_run = 0;
    tests_failed = 0;
    rst_n = 1'b0;
    cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; ba = '0; addr = '0;
    model_reset();
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    compare("R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1, 1, 3'b111, 2'd0, 13'h0, "R1 idle after release");

    // R2 deselect and no-operation
    step(1, 1, 3'b011, 2'd1, 13'h0555, "R2 deselect ignores activate");
    step(1, 0, 3'b111, 2'd0, 13'h0, "R2 nop accepted");

    // R3 activates
    step(1, 0, 3'b011, 2'd0, 13'h1ABC, "R3 activate bank0");
    step(1, 0, 3'b011, 2'd2, 13'h0F0F, "R3 activate bank2");
    step(1, 0, 3'b011, 2'd3, 13'h1FFF, "R3 activate bank3 max row");

    // R4 read/write columns
    step(1, 0, 3'b101, 2'd0, 13'h12FF, "R4 read bank0 column");
    step(1, 0, 3'b100, 2'd2, 13'h0005, "R4 write bank2 column");
    step(1, 0, 3'b111, 2'd1, 13'h0177, "R4 column held after nop");

    // R7 illegal commands
    step(1, 0, 3'b101, 2'd1, 13'h0010, "R7 read to idle bank");
    step(1, 0, 3'b011, 2'd0, 13'h0001, "R7 activate to open bank");
    step(1, 0, 3'b110, 2'd0, 13'h0000, "R7 unsupported code");
    step(1, 0, 3'b111, 2'd0, 13'h0000, "R11 illegal pulse ends");

    // R8, R9 with open banks
    step(1, 0, 3'b001, 2'd0, 13'h0000, "R8 refresh with open banks");
    step(1, 0, 3'b000, 2'd1, 13'h0123, "R9 mode set with open banks");

    // R5 auto-precharge
    step(1, 0, 3'b100, 2'd3, 13'h04AA, "R5 write with auto precharge");
    step(1, 0, 3'b101, 2'd3, 13'h0001, "R5 bank3 closed after auto precharge");
    step(1, 0, 3'b101, 2'd0, 13'h0003, "R5 read without auto precharge");

    // R6 precharge
    step(1, 0, 3'b010, 2'd2, 13'h0000, "R6 single bank precharge");
    step(1, 0, 3'b011, 2'd1, 13'h0A0A, "R3 activate bank1");
    step(1, 0, 3'b010, 2'd3, 13'h0400, "R6 all bank precharge");
    step(1, 0, 3'b010, 2'd2, 13'h0000, "R6 precharge of idle bank");

    // R8 refresh all idle
    step(1, 0, 3'b001, 2'd0, 13'h0000, "R8 refresh all idle");

    // R10 power-down
    step(1, 0, 3'b011, 2'd1, 13'h0042, "R3 activate bank1 again");
    step(0, 0, 3'b111, 2'd0, 13'h0000, "R10 enter power down");
    step(0, 0, 3'b011, 2'd2, 13'h0033, "R10 command ignored in power down");
    step(1, 0, 3'b011, 2'd2, 13'h0033, "R10 wake edge ignores command");
    step(1, 0, 3'b011, 2'd2, 13'h0033, "R10 awake again");
    step(0, 0, 3'b001, 2'd0, 13'h0000, "R10 refresh with open banks gives power down");
    step(1, 1, 3'b111, 2'd0, 13'h0000, "R10 wake from power down");
    step(1, 0, 3'b010, 2'd0, 13'h0400, "R6 close all before self refresh");
    step(0, 0, 3'b001, 2'd0, 13'h0000, "R10 enter self refresh");
    step(0, 1, 3'b111, 2'd0, 13'h0000, "R10 hold self refresh");
    step(1, 0, 3'b001, 2'd0, 13'h0000, "R10 exit self refresh");
    step(1, 0, 3'b111, 2'd0, 13'h0000, "R11 after wake");

    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule